// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects five interrupt sources and hands the CPU one request at a time. The sources, in polling order, are external input 0, timer 0 flag, external input 1, timer 1 flag and the serial flag. Source indices run 0 to 4 in that order. The two external inputs are active-low pins. Each has its own mode bit that chooses between level sensing and falling-edge sensing. The timer and serial flags are active-high level inputs owned by outside logic, and this block never clears them.

Each source has its own enable bit, and one global enable gates all of them. A per-source priority bit places the source at the low or high level. The controller picks a single winner, shows its fixed vector address and raises a request. It then tracks the service routine through an acknowledge strobe and a return strobe. This allows one high-level service to nest inside a low-level one, and never more than that.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Synchronous reset drives `irq_req` low, clears both in-service bits (`svc` = 2'b00) and clears any latched edge flag.
- R2: A source takes part only while its `src_en` bit and `glob_en` are both 1. With `glob_en` = 0, `irq_req` stays low.
- R3: The vector for source index i is 16'h0003 + 8*i, which gives 0003, 000B, 0013, 001B and 0023. `irq_src` carries i.
- R4: Among requests of the same level, the lowest index wins: ext0, then timer0, then ext1, then timer1, then serial.
- R5: A pending high-level source (`src_hi` bit = 1) wins over every low-level source, whatever their indices.
- R6: When `ext_edge` bit = 0 (level mode), the external request equals the inverted pin, one clock after the pin is sampled, and nothing is latched.
- R7: When `ext_edge` bit = 1 (edge mode), a sample of 1 followed by a sample of 0 on the next clock latches a request. The request stays after the pin rises. A pin that stays low does not raise it again.
- R8: An `ack` of an edge-mode external source clears its latched flag. If a new falling edge arrives in the same cycle as that `ack`, the flag stays set.
- R9: `ack` while `irq_req` = 1 sets the in-service bit of the winner's level: `svc[0]` for low, `svc[1]` for high.
- R10: While `svc[0]` = 1, low-level requests are held back and a high-level request is still presented, with `irq_hi` = 1.
- R11: While `svc[1]` = 1, no request is presented.
- R12: `reti` clears only the highest in-service bit that is set.
- R13: An `ack` does not clear the timer or serial flags. A source whose flag is still high requests again once the service level is freed.
- R14: An `ack` while `irq_req` = 0 leaves `svc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n | input | 2 | External request pins, active-low |
| tmr_flag | input | 2 | Timer 0 / timer 1 overflow flags |
| ser_flag | input | 1 | Serial port flag |
| src_en | input | 5 | Per-source enable, bit i for source i |
| glob_en | input | 1 | Global enable |
| src_hi | input | 5 | Per-source priority, 1 = high level |
| ext_edge | input | 2 | Per-external-input mode, 1 = falling edge |
| ack | input | 1 | CPU takes the presented vector |
| reti | input | 1 | CPU returns from a service routine |
| irq_req | output | 1 | Request to the CPU |
| irq_hi | output | 1 | Presented request is high level |
| irq_src | output | 3 | Index of the presented source |
| irq_vec | output | 16 | Vector address of the presented source |
| svc | output | 2 | In-service bits: [0] low, [1] high |

## Verification
Two collisions can land on the same clock edge. The first is the acknowledge that clears an edge-mode flag. The second is a fresh falling edge on that same pin. The bench provokes them together by pulling the pin low in the cycle where `ack` is strobed, with the source at high level. The high in-service bit then hides the request until `reti`. The request must reappear after `reti`, which shows that the new edge won over the clear.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_SRC   = 5;
    localparam int NUM_EXT   = 2;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int VEC_W     = 16;
    localparam int VEC_BASE  = 3;
    localparam int VEC_STEP  = 8;
    localparam int NUM_LVL   = 2;

    typedef logic [IDX_W-1:0] src_idx_t;

    typedef struct packed {
        logic     valid;
        logic     hi;
        src_idx_t idx;
    } pick_t;

    // position of external input k in the polling order
    function automatic src_idx_t ext_pos(input int k);
        return src_idx_t'(2 * k);
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input src_idx_t idx);
        return VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(idx);
    endfunction

    // lowest set index wins
    function automatic src_idx_t first_idx(input logic [NUM_SRC-1:0] v);
        src_idx_t r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = src_idx_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_ext_detect.sv
module irq_ext_detect (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    logic samp_q;
    logic flag_q;
    logic fall;

    // previous sample high, current pin low
    assign fall = samp_q & ~pin_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            samp_q <= pin_n;
            if (edge_mode)
                flag_q <= (flag_q & ~clr) | fall;
            else
                flag_q <= 1'b0;
        end
    end

    assign req = edge_mode ? flag_q : ~samp_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] en,
    input  logic               glob_en,
    input  logic [NUM_SRC-1:0] hi,
    input  logic [NUM_LVL-1:0] svc,
    output pick_t              pick
);
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] pend_hi;
    logic [NUM_SRC-1:0] pend_lo;

    assign pend    = raw & en & {NUM_SRC{glob_en}};
    assign pend_hi = pend & hi;
    assign pend_lo = pend & ~hi;

    always_comb begin
        pick = '0;
        if (!svc[1]) begin
            if (|pend_hi) begin
                pick.valid = 1'b1;
                pick.hi    = 1'b1;
                pick.idx   = first_idx(pend_hi);
            end else if (|pend_lo && !svc[0]) begin
                pick.valid = 1'b1;
                pick.hi    = 1'b0;
                pick.idx   = first_idx(pend_lo);
            end
        end
    end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic               take_hi,
    input  logic               reti,
    output logic [NUM_LVL-1:0] svc
);
    logic [NUM_LVL-1:0] svc_q;
    logic [NUM_LVL-1:0] svc_n;

    always_comb begin
        svc_n = svc_q;
        if (reti) begin
            if (svc_q[1]) svc_n[1] = 1'b0;
            else          svc_n[0] = 1'b0;
        end
        if (take) svc_n[take_hi] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) svc_q <= '0;
        else     svc_q <= svc_n;
    end

    assign svc = svc_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_EXT-1:0]   ext_n,
    input  logic [1:0]           tmr_flag,
    input  logic                 ser_flag,
    input  logic [NUM_SRC-1:0]   src_en,
    input  logic                 glob_en,
    input  logic [NUM_SRC-1:0]   src_hi,
    input  logic [NUM_EXT-1:0]   ext_edge,
    input  logic                 ack,
    input  logic                 reti,
    output logic                 irq_req,
    output logic                 irq_hi,
    output logic [IDX_W-1:0]     irq_src,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [NUM_LVL-1:0]   svc
);
    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_EXT-1:0] ext_clr;
    logic [NUM_SRC-1:0] raw;
    pick_t              pick;
    logic               take;

    assign take = ack & pick.valid;

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        assign ext_clr[k] = take && (pick.idx == ext_pos(k));
        irq_ext_detect u_det (
            .clk       (clk),
            .rst       (rst),
            .pin_n     (ext_n[k]),
            .edge_mode (ext_edge[k]),
            .clr       (ext_clr[k]),
            .req       (ext_req[k])
        );
    end

    assign raw = {ser_flag, tmr_flag[1], ext_req[1], tmr_flag[0], ext_req[0]};

    irq_arbiter u_arb (
        .raw     (raw),
        .en      (src_en),
        .glob_en (glob_en),
        .hi      (src_hi),
        .svc     (svc),
        .pick    (pick)
    );

    irq_svc_track u_svc (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .take_hi (pick.hi),
        .reti    (reti),
        .svc     (svc)
    );

    assign irq_req = pick.valid;
    assign irq_hi  = pick.hi;
    assign irq_src = pick.idx;
    assign irq_vec = vec_of(pick.idx);

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 glob_en,
    input logic                 ack,
    input logic                 reti,
    input logic                 irq_req,
    input logic                 irq_hi,
    input logic [IDX_W-1:0]     irq_src,
    input logic [VEC_W-1:0]     irq_vec,
    input logic [NUM_LVL-1:0]   svc
);
    a_r2_global_off: assert property (@(posedge clk) disable iff (rst)
        !glob_en |-> !irq_req);

    a_r3_vector_step: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_vec == 16'h0003 + 16'(irq_src) * 16'd8);

    a_r9_ack_hi_sets: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_req && irq_hi) |=> svc[1]);

    a_r10_low_blocked: assert property (@(posedge clk) disable iff (rst)
        (svc[0] && irq_req) |-> irq_hi);

    a_r11_high_blocks_all: assert property (@(posedge clk) disable iff (rst)
        svc[1] |-> !irq_req);

    a_r12_reti_top_only: assert property (@(posedge clk) disable iff (rst)
        (reti && !ack && svc[1]) |=> (!svc[1] && svc[0] == $past(svc[0])));

    a_r14_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq_req && !reti) |=> svc == $past(svc));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .glob_en (glob_en),
    .ack     (ack),
    .reti    (reti),
    .irq_req (irq_req),
    .irq_hi  (irq_hi),
    .irq_src (irq_src),
    .irq_vec (irq_vec),
    .svc     (svc)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  ext_n;
    logic [1:0]  tmr_flag;
    logic        ser_flag;
    logic [4:0]  src_en;
    logic        glob_en;
    logic [4:0]  src_hi;
    logic [1:0]  ext_edge;
    logic        ack;
    logic        reti;
    logic        irq_req;
    logic        irq_hi;
    logic [2:0]  irq_src;
    logic [15:0] irq_vec;
    logic [1:0]  svc;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst(rst), .ext_n(ext_n), .tmr_flag(tmr_flag),
        .ser_flag(ser_flag), .src_en(src_en), .glob_en(glob_en),
        .src_hi(src_hi), .ext_edge(ext_edge), .ack(ack), .reti(reti),
        .irq_req(irq_req), .irq_hi(irq_hi), .irq_src(irq_src),
        .irq_vec(irq_vec), .svc(svc)
    );

    // {ext_n[2], tmr[2], ser, en[5], glob, hi[5], exp_req, exp_src[3]}
    localparam int NV = 11;
    localparam logic [19:0] TBL [0:NV-1] = '{
        {2'b11, 2'b00, 1'b0, 5'b11111, 1'b1, 5'b00000, 1'b0, 3'd0},
        {2'b10, 2'b00, 1'b0, 5'b11111, 1'b1, 5'b00000, 1'b1, 3'd0},
        {2'b11, 2'b01, 1'b0, 5'b11111, 1'b1, 5'b00000, 1'b1, 3'd1},
        {2'b00, 2'b11, 1'b1, 5'b11111, 1'b1, 5'b00000, 1'b1, 3'd0},
        {2'b00, 2'b11, 1'b1, 5'b11111, 1'b1, 5'b10000, 1'b1, 3'd4},
        {2'b00, 2'b11, 1'b1, 5'b11111, 1'b0, 5'b00000, 1'b0, 3'd0},
        {2'b00, 2'b11, 1'b1, 5'b11000, 1'b1, 5'b00000, 1'b1, 3'd3},
        {2'b00, 2'b11, 1'b1, 5'b00000, 1'b1, 5'b00000, 1'b0, 3'd0},
        {2'b01, 2'b10, 1'b0, 5'b11111, 1'b1, 5'b01000, 1'b1, 3'd3},
        {2'b01, 2'b01, 1'b0, 5'b11111, 1'b1, 5'b00000, 1'b1, 3'd1},
        {2'b00, 2'b11, 1'b1, 5'b11111, 1'b1, 5'b00110, 1'b1, 3'd1}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; tick(); reti = 1'b0;
    endtask

    task automatic idle();
        ext_n = 2'b11; tmr_flag = 2'b00; ser_flag = 1'b0;
        src_en = 5'b11111; glob_en = 1'b1; src_hi = 5'b00000;
        ack = 1'b0; reti = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        ext_edge = 2'b00;
        rst = 1'b1;
        @(negedge clk);
        tick(2);
        rst = 1'b0;
        tick();
        chk("R1 req after reset", 32'(irq_req), 32'd0);
        chk("R1 svc after reset", 32'(svc), 32'd0);

        // table walk: level mode, arbitration and masking (R2 R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            ext_n    = TBL[i][19:18];
            tmr_flag = TBL[i][17:16];
            ser_flag = TBL[i][15];
            src_en   = TBL[i][14:10];
            glob_en  = TBL[i][9];
            src_hi   = TBL[i][8:4];
            tick(2);
            chk($sformatf("R2 R4 R5 R6 req row %0d", i), 32'(irq_req), 32'(TBL[i][3]));
            if (TBL[i][3]) begin
                chk($sformatf("R4 R5 src row %0d", i), 32'(irq_src), 32'(TBL[i][2:0]));
                chk($sformatf("R3 vec row %0d", i), 32'(irq_vec),
                    32'h3 + 32'(TBL[i][2:0]) * 32'd8);
            end
        end

        // R6: level mode has no memory
        idle();
        ext_n = 2'b10; tick();
        chk("R6 level one-cycle latency", 32'(irq_req), 32'd1);
        ext_n = 2'b11; tick();
        chk("R6 level release", 32'(irq_req), 32'd0);

        // R7 edge latch
        ext_edge = 2'b11; tick(2);
        chk("R7 idle in edge mode", 32'(irq_req), 32'd0);
        ext_n = 2'b10; tick();
        chk("R7 falling edge latches", 32'(irq_req), 32'd1);
        ext_n = 2'b11; tick();
        chk("R7 flag held after rise", 32'(irq_req), 32'd1);
        chk("R7 src", 32'(irq_src), 32'd0);
        pulse_ack();
        chk("R8 ack clears edge flag", 32'(irq_req), 32'd0);
        chk("R9 low level in service", 32'(svc), 32'b01);
        pulse_reti();
        chk("R12 reti clears low", 32'(svc), 32'b00);

        // R7: pin held low does not retrigger
        ext_n = 2'b10; tick();
        pulse_ack();
        pulse_reti();
        tick(2);
        chk("R7 no retrigger while low", 32'(irq_req), 32'd0);
        ext_n = 2'b11; tick();

        // R8: new edge in the same cycle as ack keeps the flag
        src_hi = 5'b00001;
        ext_n = 2'b10; tick();
        ext_n = 2'b11; tick();
        chk("R8 setup request", 32'(irq_req), 32'd1);
        ext_n = 2'b10; ack = 1'b1; tick(); ack = 1'b0;
        chk("R9 high level in service", 32'(svc), 32'b10);
        chk("R11 high service hides request", 32'(irq_req), 32'd0);
        ext_n = 2'b11;
        pulse_reti();
        chk("R8 edge beats clear", 32'(irq_req), 32'd1);
        chk("R8 edge beats clear src", 32'(irq_src), 32'd0);
        pulse_ack();
        pulse_reti();
        chk("R8 cleared after second ack", 32'(irq_req), 32'd0);

        // nesting with level timer flags (R10 R11 R12 R13)
        idle(); ext_edge = 2'b00;
        tmr_flag = 2'b01; tick();
        chk("R4 timer0 presented", 32'(irq_src), 32'd1);
        pulse_ack();
        chk("R9 svc low", 32'(svc), 32'b01);
        chk("R10 low blocked by low", 32'(irq_req), 32'd0);
        src_hi = 5'b01000; tmr_flag = 2'b11; tick();
        chk("R10 high preempts", 32'(irq_req), 32'd1);
        chk("R10 preempt is high", 32'(irq_hi), 32'd1);
        chk("R10 preempt src", 32'(irq_src), 32'd3);
        pulse_ack();
        chk("R9 both levels", 32'(svc), 32'b11);
        chk("R11 nothing while high", 32'(irq_req), 32'd0);
        pulse_reti();
        chk("R12 only high cleared", 32'(svc), 32'b01);
        chk("R13 timer1 requests again", 32'(irq_src), 32'd3);
        chk("R13 timer1 req", 32'(irq_req), 32'd1);
        tmr_flag = 2'b01; tick();
        chk("R10 low still blocked", 32'(irq_req), 32'd0);
        pulse_reti();
        chk("R12 low cleared", 32'(svc), 32'b00);
        chk("R13 timer0 requests again", 32'(irq_src), 32'd1);
        chk("R13 timer0 req", 32'(irq_req), 32'd1);

        // R14: ack without a request
        idle(); tick();
        pulse_ack();
        chk("R14 idle ack ignored", 32'(svc), 32'b00);

        // R1: reset clears a latched edge flag
        ext_edge = 2'b01;
        ext_n = 2'b10; tick();
        ext_n = 2'b11; tick();
        chk("R1 flag set before reset", 32'(irq_req), 32'd1);
        rst = 1'b1; tick(); rst = 1'b0;
        chk("R1 flag cleared by reset", 32'(irq_req), 32'd0);
        tick();
        chk("R1 stays clear", 32'(irq_req), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule